// File: doc/BRIEF.md
# Ring Buffer Address Generator

This block forms external sample-memory byte addresses for an audio effect processor that keeps its delay lines in a ring buffer. Each address request names one of 32 base-address slots and carries three control flags. The flags add the low part of an offset register, add one word, and choose between ring mode and a flat table mode. In ring mode a per-sample down-counter is added and the result wraps inside the ring length. In table mode the counter is skipped and the result wraps at 16 bits. The word address is then doubled, the ring base (already a byte address) is added, and the sum is cut to the width of the memory.

The block also owns the ring counter, which steps down once per sample strobe and reloads from the ring mask when it reaches zero. The effect program issues memory requests only on odd program steps, so a request made on an even step is dropped. The address output is registered and comes with a one-cycle valid pulse.

Top module: `ring_addr_gen`

## Requirements
- R1: While reset is held and after it is released, `addr_valid` is 0, `addr` is 0 and `ring_cnt` is 1 until the first accepted strobe.
- R2: A request with `step[0]`=1 raises `addr_valid` for exactly one cycle, on the cycle after the request. A request with `step[0]`=0 produces no valid pulse and leaves `addr` unchanged.
- R3: The base word address is table slot `sel_idx` (5 bits, 32 slots, 16 bits each). A slot is written with `tbl_wdata` at `tbl_idx` when `tbl_we`=1, and the new value can be used from the next cycle.
- R4: When `use_ofs`=1, `ofs_reg[11:0]` is added to the word address. Bits 15:12 have no effect.
- R5: When `next_word`=1, one is added to the word address.
- R6: When `table_mode`=0, the word address is (base + offset + increment + `ring_cnt`) AND `ring_mask`.
- R7: When `table_mode`=1, the word address is (base + offset + increment) mod 65536, and `ring_cnt` has no effect.
- R8: `addr` = ((word << 1) + `ring_base`) mod 2^AW, with AW = 21 for a 2 MiB memory (default) and 23 for 8 MiB.
- R9: On each cycle with `sample_end`=1, `ring_cnt` decrements by one. If the decremented value is 0, it loads `ring_mask`+1 instead. Otherwise it holds its value.
- R10: A request in the same cycle as `sample_end` uses the counter value before the decrement.
- R11: The memory-size parameter accepts only 2 MiB or 8 MiB. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Base table write enable |
| tbl_idx | input | 5 | Base table write slot |
| tbl_wdata | input | 16 | Base table write word address |
| req | input | 1 | Address request strobe |
| step | input | 7 | Program step number of the request |
| sel_idx | input | 5 | Base table slot for the request |
| use_ofs | input | 1 | Add low 12 bits of the offset register |
| next_word | input | 1 | Add one word |
| table_mode | input | 1 | 1: flat 16-bit wrap, 0: ring mode |
| ofs_reg | input | 16 | Address offset register |
| ring_mask | input | 16 | Ring length minus one |
| ring_base | input | 23 | Ring base byte address |
| sample_end | input | 1 | End-of-sample strobe, steps the counter |
| addr_valid | output | 1 | Address result valid pulse |
| addr | output | 21 | Byte address (AW bits) |
| ring_cnt | output | 17 | Current ring counter |

## Verification
On every cycle the assertions check the counter's step, reload and hold rules. They also check that a valid pulse only follows an odd-step request, that even-step requests and idle cycles leave the address register untouched, and that a table write lands in its slot. The arithmetic itself can only be shown by the bench scenarios. Those cover offset truncation, the increment, wrap inside the ring mask, the 16-bit wrap in table mode, wrap of the byte sum at the memory width, a counter reload after a mask change, and a request that coincides with the sample strobe.

// File: rtl/rbag_pkg.sv
package rbag_pkg;
  localparam int unsigned TBL_DEPTH = 32;
  localparam int unsigned IDX_W     = $clog2(TBL_DEPTH);
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned OFS_W     = 16;
  localparam int unsigned OFS_USED  = 12;
  localparam int unsigned STEP_W    = 7;
  localparam int unsigned RBP_W     = 23;
  localparam int unsigned CNT_W     = WORD_W + 1;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             use_ofs;
    logic             next_word;
    logic             table_mode;
  } addr_ctl_t;
endpackage

// File: rtl/rbag_base_table.sv
module rbag_base_table #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 16,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic          slot_en;
    logic [DW-1:0] slot_d;
    always_comb begin
      slot_en = wr_en && (wr_idx == IW'(i));
      slot_d  = slot_en ? wr_data : slot_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[i] <= '0;
      else        slot_q[i] <= slot_d;
    end
  end

  assign rd_data = slot_q[rd_idx];

  // R3: a write is visible in the selected slot on the next cycle
  assert_tbl_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en)) |-> (slot_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/rbag_ring_ctr.sv
module rbag_ring_ctr #(
  parameter int unsigned MASK_W = 16,
  localparam int unsigned CW    = MASK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [MASK_W-1:0] ring_mask,
  output logic [CW-1:0]     cnt
);
  logic [CW-1:0] cnt_q, cnt_d, dec;

  always_comb begin
    dec   = cnt_q - CW'(1);
    cnt_d = cnt_q;
    if (step_en) begin
      if (dec == '0) cnt_d = {1'b0, ring_mask} + CW'(1);
      else           cnt_d = dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(1);
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R9: counter never rests at zero
  assert_cnt_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);
  // R9: plain decrement
  assert_cnt_dec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(step_en) && ($past(cnt_q) != CW'(1)))
      |-> (cnt_q == $past(cnt_q) - CW'(1)));
  // R9: reload from mask on reaching zero
  assert_cnt_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(step_en) && ($past(cnt_q) == CW'(1)))
      |-> (cnt_q == {1'b0, $past(ring_mask)} + CW'(1)));
  // R9: hold without strobe
  assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(step_en)) |-> $stable(cnt_q));
endmodule

// File: rtl/rbag_addr_calc.sv
module rbag_addr_calc #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned OFS_U  = 12,
  parameter int unsigned CW     = 17,
  parameter int unsigned RBP_W  = 23,
  parameter int unsigned AW     = 21,
  localparam int unsigned SUM_W = CW + 2,
  localparam int unsigned BSUM_W = RBP_W + 1
) (
  input  logic [WORD_W-1:0] base,
  input  logic [OFS_U-1:0]  ofs_lo,
  input  logic              use_ofs,
  input  logic              next_word,
  input  logic              table_mode,
  input  logic [CW-1:0]     cnt,
  input  logic [WORD_W-1:0] ring_mask,
  input  logic [RBP_W-1:0]  ring_base,
  output logic [AW-1:0]     byte_addr
);
  logic [SUM_W-1:0]  word_sum;
  logic [WORD_W-1:0] word;
  logic [BSUM_W-1:0] byte_sum;
  logic              unused_hi;

  always_comb begin
    word_sum = SUM_W'(base);
    if (use_ofs)     word_sum = word_sum + SUM_W'(ofs_lo);
    if (next_word)   word_sum = word_sum + SUM_W'(1);
    if (!table_mode) word_sum = word_sum + SUM_W'(cnt);
    word = table_mode ? word_sum[WORD_W-1:0]
                      : (word_sum[WORD_W-1:0] & ring_mask);
    byte_sum  = BSUM_W'({word, 1'b0}) + BSUM_W'(ring_base);
    byte_addr = byte_sum[AW-1:0];
  end

  assign unused_hi = ^{word_sum[SUM_W-1:WORD_W], byte_sum[BSUM_W-1:AW]};
endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen
  import rbag_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 2097152,
  localparam int unsigned AW = (MEM_BYTES == 8388608) ? 23 : 21
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tbl_we,
  input  logic [IDX_W-1:0]    tbl_idx,
  input  logic [WORD_W-1:0]   tbl_wdata,
  input  logic                req,
  input  logic [STEP_W-1:0]   step,
  input  logic [IDX_W-1:0]    sel_idx,
  input  logic                use_ofs,
  input  logic                next_word,
  input  logic                table_mode,
  input  logic [OFS_W-1:0]    ofs_reg,
  input  logic [WORD_W-1:0]   ring_mask,
  input  logic [RBP_W-1:0]    ring_base,
  input  logic                sample_end,
  output logic                addr_valid,
  output logic [AW-1:0]       addr,
  output logic [CNT_W-1:0]    ring_cnt
);
  // R11: only two memory sizes are legal
  if (MEM_BYTES != 2097152 && MEM_BYTES != 8388608) begin : g_bad_mem_size
    $error("ring_addr_gen: MEM_BYTES must be 2097152 or 8388608");
  end

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  addr_ctl_t         ctl;
  logic [WORD_W-1:0] base_word;
  logic [AW-1:0]     calc_addr;
  logic              accept;
  logic              unused_in;

  always_comb begin
    ctl.idx        = sel_idx;
    ctl.use_ofs    = use_ofs;
    ctl.next_word  = next_word;
    ctl.table_mode = table_mode;
    accept         = req && step[0];
  end

  rbag_base_table #(.DEPTH(TBL_DEPTH), .DW(WORD_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (tbl_we),
    .wr_idx  (tbl_idx),
    .wr_data (tbl_wdata),
    .rd_idx  (ctl.idx),
    .rd_data (base_word)
  );

  rbag_ring_ctr #(.MASK_W(WORD_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .step_en   (sample_end),
    .ring_mask (ring_mask),
    .cnt       (ring_cnt)
  );

  rbag_addr_calc #(
    .WORD_W (WORD_W),
    .OFS_U  (OFS_USED),
    .CW     (CNT_W),
    .RBP_W  (RBP_W),
    .AW     (AW)
  ) u_calc (
    .base       (base_word),
    .ofs_lo     (ofs_reg[OFS_USED-1:0]),
    .use_ofs    (ctl.use_ofs),
    .next_word  (ctl.next_word),
    .table_mode (ctl.table_mode),
    .cnt        (ring_cnt),
    .ring_mask  (ring_mask),
    .ring_base  (ring_base),
    .byte_addr  (calc_addr)
  );

  // output register with explicit enable
  logic [AW-1:0] addr_q, addr_d;
  logic          valid_q, valid_d;

  always_comb begin
    valid_d = accept;
    addr_d  = accept ? calc_addr : addr_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      valid_q <= valid_d;
    end
  end

  assign addr_valid = valid_q;
  assign addr       = addr_q;
  assign unused_in  = ^{ofs_reg[OFS_W-1:OFS_USED], step[STEP_W-1:1]};

  // R2: a valid pulse only follows an odd-step request
  assert_valid_source_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(rst_int_n) && valid_q) |-> ($past(req) && $past(step[0])));
  // R2: even-step requests are dropped
  assert_even_dropped_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req && !step[0]) |=> !valid_q);
  // R2: address register holds when nothing is accepted
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(req && step[0]) |=> $stable(addr_q));
  // R2: valid lasts one cycle for a single request
  assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_q && !(req && step[0])) |=> !valid_q);
endmodule

// File: tb/ring_addr_gen_tb.sv
module ring_addr_gen_tb;
  localparam int AW = 21;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_we;
  logic [4:0]  tbl_idx;
  logic [15:0] tbl_wdata;
  logic        req;
  logic [6:0]  step;
  logic [4:0]  sel_idx;
  logic        use_ofs, next_word, table_mode;
  logic [15:0] ofs_reg;
  logic [15:0] ring_mask;
  logic [22:0] ring_base;
  logic        sample_end;
  logic        addr_valid;
  logic [AW-1:0] addr;
  logic [16:0] ring_cnt;

  always #10 clk = ~clk;  // 50 MHz

  ring_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_wdata(tbl_wdata), .req(req), .step(step), .sel_idx(sel_idx),
    .use_ofs(use_ofs), .next_word(next_word), .table_mode(table_mode),
    .ofs_reg(ofs_reg), .ring_mask(ring_mask), .ring_base(ring_base),
    .sample_end(sample_end), .addr_valid(addr_valid), .addr(addr),
    .ring_cnt(ring_cnt)
  );

  typedef struct { logic [AW-1:0] a; string tag; } exp_t;
  exp_t exp_q[$];

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] m_tbl [32];
  logic [16:0] m_cnt;
  bit monitor_on = 1'b0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  function automatic logic [AW-1:0] model(input logic [4:0] idx, input bit uo,
      input bit nw, input bit tm, input logic [15:0] ofs);
    longint s, w, b;
    s = m_tbl[idx];
    if (uo) s += ofs[11:0];
    if (nw) s += 1;
    if (!tm) s += m_cnt;
    w = tm ? (s & 'hFFFF) : (s & ring_mask);
    b = (w << 1) + ring_base;
    return b[AW-1:0];
  endfunction

  task automatic model_step();
    logic [16:0] d;
    d = m_cnt - 1;
    m_cnt = (d == 0) ? ({1'b0, ring_mask} + 17'd1) : d;
  endtask

  task automatic write_tbl(input logic [4:0] idx, input logic [15:0] val);
    tbl_we = 1'b1; tbl_idx = idx; tbl_wdata = val;
    tick();
    tbl_we = 1'b0;
    m_tbl[idx] = val;
  endtask

  task automatic issue(input logic [4:0] idx, input bit uo, input bit nw, input bit tm,
      input logic [15:0] ofs, input logic [6:0] stp, input bit se, input string tag);
    exp_t e;
    if (stp[0]) begin
      e.a = model(idx, uo, nw, tm, ofs);
      e.tag = tag;
      exp_q.push_back(e);
    end
    req = 1'b1; sel_idx = idx; use_ofs = uo; next_word = nw; table_mode = tm;
    ofs_reg = ofs; step = stp; sample_end = se;
    tick();
    req = 1'b0; sample_end = 1'b0;
    if (se) model_step();
  endtask

  task automatic sample_pulse();
    sample_end = 1'b1;
    tick();
    sample_end = 1'b0;
    model_step();
  endtask

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (monitor_on && addr_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected valid", addr, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(addr == e.a, e.tag, addr, e.a);
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [AW-1:0] hold;
    rst_n = 1'b0; tbl_we = 0; tbl_idx = 0; tbl_wdata = 0; req = 0; step = 0;
    sel_idx = 0; use_ofs = 0; next_word = 0; table_mode = 0; ofs_reg = 0;
    ring_mask = 16'h03FF; ring_base = 23'h001000; sample_end = 0;
    for (int i = 0; i < 32; i++) m_tbl[i] = '0;
    m_cnt = 17'd1;
    repeat (3) @(negedge clk);
    check(addr_valid == 1'b0, "R1 valid in reset", addr_valid, 0);
    check(addr == '0, "R1 addr in reset", addr, 0);
    check(ring_cnt == 17'd1, "R1 cnt in reset", ring_cnt, 1);
    tick(); rst_n = 1'b1;
    repeat (4) tick();
    check(addr_valid == 1'b0 && ring_cnt == 17'd1, "R1 after release", ring_cnt, 1);
    monitor_on = 1'b1;

    write_tbl(5'd0,  16'h0010);
    write_tbl(5'd5,  16'h0200);
    write_tbl(5'd17, 16'h1234);
    write_tbl(5'd31, 16'hFFF0);

    sample_pulse();
    check(ring_cnt == 17'h400, "R9 reload from 1", ring_cnt, 17'h400);
    sample_pulse();
    check(ring_cnt == 17'h3FF, "R9 decrement", ring_cnt, 17'h3FF);

    issue(5'd0,  0, 0, 0, 16'h0000, 7'd1, 0, "R3 R6 base plus ring");
    issue(5'd5,  1, 0, 0, 16'hF123, 7'd3, 0, "R4 offset low bits");
    issue(5'd5,  0, 1, 0, 16'h0000, 7'd5, 0, "R5 next word");
    issue(5'd17, 1, 1, 0, 16'h0ABC, 7'd7, 0, "R6 ring wrap");
    tick();
    hold = addr;
    issue(5'd31, 1, 1, 1, 16'h0FFF, 7'd2, 0, "R2 even step");
    tick();
    check(addr == hold, "R2 even step ignored", addr, hold);
    issue(5'd31, 1, 1, 1, 16'h0FFF, 7'd9, 0, "R7 16-bit wrap");
    issue(5'd17, 0, 0, 1, 16'h0000, 7'd11, 0, "R7 table mode A");
    sample_pulse();
    issue(5'd17, 0, 0, 1, 16'h0000, 7'd13, 0, "R7 counter ignored");
    write_tbl(5'd17, 16'h0777);
    issue(5'd17, 0, 0, 1, 16'h0000, 7'd15, 0, "R3 rewritten slot");
    ring_base = 23'h1FFF00;
    issue(5'd31, 0, 0, 1, 16'h0000, 7'd17, 0, "R8 byte wrap at 21 bits");
    ring_base = 23'h000800;
    issue(5'd5, 1, 0, 0, 16'h0040, 7'd19, 1, "R10 same-cycle strobe");
    check(ring_cnt == m_cnt, "R10 counter stepped", ring_cnt, m_cnt);
    issue(5'd5, 1, 0, 0, 16'h0040, 7'd21, 0, "R10 after step");

    ring_mask = 16'h0007;
    while (m_cnt != 17'd1) sample_pulse();
    check(ring_cnt == 17'd1, "R9 count down", ring_cnt, 1);
    sample_pulse();
    check(ring_cnt == 17'd8, "R9 reload new mask", ring_cnt, 8);
    issue(5'd5, 0, 1, 0, 16'h0000, 7'd23, 0, "R6 small ring");

    repeat (3) tick();
    check(exp_q.size() == 0, "R2 missing valid", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule